// File: doc/BRIEF.md
# DMA Stream Address and Count Sequencer

This block is the per-stream bookkeeping engine of a DMA channel. It holds a peripheral base address, two memory base pointers, an item count and a set of mode fields, all loaded through a narrow register write port. Once the stream is armed, every pulse on `beat_done` marks one finished data item: the sequencer decrements the remaining count and steps the live peripheral and memory addresses by the configured stride. The bus engine, arbiter and data FIFO sit outside and simply consume `periph_addr`, `mem_addr` and `enabled`.

When the count runs out the stream either stops, or (in wrap mode) reloads the count and both live addresses from the untouched base registers. In ping-pong mode the wrap also flips the active memory pointer, so software can refill the idle buffer while the other is in use. Three sticky status bits (half-way, finished, error) are set by hardware and cleared by a write-one-to-clear mask.

Control is a two-state machine. `ST_IDLE` is the disarmed state. `ST_RUN` is the armed state. Transitions: `ST_IDLE -> ST_RUN` on a control write with the enable bit set while the stored count is nonzero; `ST_RUN -> ST_RUN` on the last item in wrap or ping-pong mode (reload); `ST_RUN -> ST_IDLE` on a control write with the enable bit clear, on a write to the memory pointer in use, or on the last item without wrap.

Top module: `dma_seq_stream`

## Requirements
- R1: After reset the stream is disabled, `periph_addr`, `mem_addr` and `items_left` are 0, all three flags are 0 and `cur_target` is 0.
- R2: `wr_sel` selects 0 control, 1 count, 2 peripheral base, 3 memory pointer 0, 4 memory pointer 1. Control bits: [0] enable, [2:1] direction (0 periph-to-mem, 1 mem-to-periph, 2 mem-to-mem), [3] wrap, [4] ping-pong, [5] memory step enable, [6] peripheral step enable, [7] fixed 4-byte peripheral step, [9:8] memory size, [11:10] peripheral size (0 byte, 1 halfword, 2 word), [12] initial pointer. Enabling while idle loads `items_left` from the count, `periph_addr` from the peripheral base, `cur_target` from bit 12 and `mem_addr` from the pointer it names; enabling with a stored count of 0 leaves the stream disabled.
- R3: With memory step enabled, each item advances `mem_addr` by 1, 2 or 4 for memory size 0, 1 or 2; with it clear, `mem_addr` holds.
- R4: With peripheral step enabled, each item advances `periph_addr` by 1, 2 or 4 for peripheral size 0, 1 or 2, or by 4 whatever the size when the fixed step bit is set; with peripheral step clear it holds.
- R5: Each `beat_done` while enabled decrements `items_left` by one; `beat_done` while disabled changes nothing.
- R6: Without wrap or ping-pong, the last item sets the finished flag, leaves `items_left` at 0 and disables the stream.
- R7: In wrap mode the last item sets the finished flag, reloads `items_left` from the count and both live addresses from their base registers, and the stream stays enabled.
- R8: Ping-pong mode behaves as wrap mode and, at each reload, toggles `cur_target` and restarts `mem_addr` from the newly selected pointer.
- R9: The half-way flag sets on the item after which `items_left` equals the programmed count divided by two, rounded down (for a count of 1, together with the finished flag).
- R10: While running in ping-pong mode, a write to the pointer not in use is stored and used at the next reload; a write to the pointer in use is discarded, disables the stream and sets the error flag.
- R11: A control write selecting mem-to-mem direction stores wrap and ping-pong as off.
- R12: While enabled, writes to count, peripheral base, control fields other than enable, and memory pointers outside ping-pong mode are ignored; a control write with enable clear disables the stream at once, and a `beat_done` in that same cycle is not counted.
- R13: `clr_flags` bit 0 clears half-way, bit 1 finished, bit 2 error; a flag set by hardware in the same cycle as its clear stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 3 | Register select |
| wr_data | input | ADDR_W | Register write value |
| beat_done | input | 1 | One data item finished |
| clr_flags | input | 3 | Write-one-to-clear mask for the flags |
| enabled | output | 1 | Stream armed |
| cur_target | output | 1 | Memory pointer in use |
| periph_addr | output | ADDR_W | Live peripheral address |
| mem_addr | output | ADDR_W | Live memory address |
| items_left | output | CNT_W | Remaining items |
| flag_half | output | 1 | Half-way flag |
| flag_done | output | 1 | Finished flag |
| flag_err | output | 1 | Error flag |

## Verification
A wrong stride, wrong size decode or stale base shows on `periph_addr` or `mem_addr` on the very next edge after a beat, so the bench compares both after every item of a sweep over all sizes and step modes. A wrong count or reload decision surfaces at the last item of a block as a wrong `items_left`, a missing flag or an `enabled` that drops or fails to drop; a wrong pointer choice shows as a `mem_addr` jump to the wrong buffer at the reload edge. Ignored writes are only visible later, so the bench re-arms the stream and reads back the loaded count and addresses.

// File: rtl/dseq_pkg.sv
package dseq_pkg;

    typedef enum logic [1:0] {
        DIR_P2M = 2'd0,
        DIR_M2P = 2'd1,
        DIR_M2M = 2'd2,
        DIR_RSV = 2'd3
    } dir_e;

    typedef enum logic [2:0] {
        SEL_CTRL  = 3'd0,
        SEL_COUNT = 3'd1,
        SEL_PADDR = 3'd2,
        SEL_MEM0  = 3'd3,
        SEL_MEM1  = 3'd4
    } sel_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } state_e;

    // control word field positions
    localparam int unsigned CB_EN    = 0;
    localparam int unsigned CB_DIR   = 1;
    localparam int unsigned CB_WRAP  = 3;
    localparam int unsigned CB_PING  = 4;
    localparam int unsigned CB_MSTEP = 5;
    localparam int unsigned CB_PSTEP = 6;
    localparam int unsigned CB_PFIX  = 7;
    localparam int unsigned CB_MSIZE = 8;
    localparam int unsigned CB_PSIZE = 10;
    localparam int unsigned CB_TGT   = 12;

    typedef struct packed {
        dir_e       dir;
        logic       wrap;
        logic       ping;
        logic       mstep;
        logic       pstep;
        logic       pfix;
        logic [1:0] msize;
        logic [1:0] psize;
        logic       init_tgt;
    } ctl_t;

    function automatic logic [2:0] size_bytes(input logic [1:0] sz);
        case (sz)
            2'd0:    size_bytes = 3'd1;
            2'd1:    size_bytes = 3'd2;
            default: size_bytes = 3'd4;
        endcase
    endfunction

endpackage

// File: rtl/dseq_regs.sv
module dseq_regs
    import dseq_pkg::*;
#(
    parameter int unsigned ADDR_W = 32,
    parameter int unsigned CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [2:0]        wr_sel,
    input  logic [ADDR_W-1:0] wr_data,
    input  logic              running,
    input  logic              cur_tgt,
    output ctl_t              ctl_q,
    output ctl_t              ctl_d,
    output logic [CNT_W-1:0]  cnt_q,
    output logic [ADDR_W-1:0] pbase_q,
    output logic [ADDR_W-1:0] m0_q,
    output logic [ADDR_W-1:0] m1_q,
    output logic              en_req,
    output logic              dis_req,
    output logic              clash
);

    logic is_ctl, is_cnt, is_pad, is_m0, is_m1;
    logic m0_ok, m1_ok;
    ctl_t ctl_dec;

    always_comb begin
        is_ctl = wr_en && (wr_sel == SEL_CTRL);
        is_cnt = wr_en && (wr_sel == SEL_COUNT);
        is_pad = wr_en && (wr_sel == SEL_PADDR);
        is_m0  = wr_en && (wr_sel == SEL_MEM0);
        is_m1  = wr_en && (wr_sel == SEL_MEM1);
    end

    // decode of a control word; mem-to-mem strips wrap and ping-pong
    always_comb begin
        ctl_dec.dir      = dir_e'(wr_data[CB_DIR +: 2]);
        ctl_dec.wrap     = wr_data[CB_WRAP] && (ctl_dec.dir != DIR_M2M);
        ctl_dec.ping     = wr_data[CB_PING] && (ctl_dec.dir != DIR_M2M);
        ctl_dec.mstep    = wr_data[CB_MSTEP];
        ctl_dec.pstep    = wr_data[CB_PSTEP];
        ctl_dec.pfix     = wr_data[CB_PFIX];
        ctl_dec.msize    = wr_data[CB_MSIZE +: 2];
        ctl_dec.psize    = wr_data[CB_PSIZE +: 2];
        ctl_dec.init_tgt = wr_data[CB_TGT];
    end

    always_comb begin
        ctl_d   = (is_ctl && !running) ? ctl_dec : ctl_q;
        en_req  = is_ctl && wr_data[CB_EN];
        dis_req = is_ctl && !wr_data[CB_EN] && running;
        clash   = running && ctl_q.ping &&
                  ((is_m0 && !cur_tgt) || (is_m1 && cur_tgt));
        m0_ok   = is_m0 && (!running || (ctl_q.ping && cur_tgt));
        m1_ok   = is_m1 && (!running || (ctl_q.ping && !cur_tgt));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q   <= '0;
            cnt_q   <= '0;
            pbase_q <= '0;
            m0_q    <= '0;
            m1_q    <= '0;
        end else begin
            ctl_q <= ctl_d;
            if (is_cnt && !running) cnt_q   <= wr_data[CNT_W-1:0];
            if (is_pad && !running) pbase_q <= wr_data;
            if (m0_ok)              m0_q    <= wr_data;
            if (m1_ok)              m1_q    <= wr_data;
        end
    end

    AST_FROZEN_WHILE_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        running |=> ($stable(cnt_q) && $stable(pbase_q) && $stable(ctl_q))); // R12

    AST_M2M_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.dir == DIR_M2M) |-> !(ctl_q.wrap || ctl_q.ping)); // R11

    AST_CLASH_DROPS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        clash |=> ($stable(m0_q) && $stable(m1_q))); // R10

endmodule

// File: rtl/dseq_fsm.sv
module dseq_fsm
    import dseq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic en_req,
    input  logic dis_req,
    input  logic clash,
    input  logic beat_done,
    input  logic last_item,
    input  logic wrap,
    input  logic cnt_nz,
    output logic running,
    output logic start,
    output logic advance
);

    state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (en_req && cnt_nz) state_d = ST_RUN;
            end
            ST_RUN: begin
                if (dis_req || clash)                       state_d = ST_IDLE;
                else if (beat_done && last_item && !wrap)   state_d = ST_IDLE;
            end
        endcase
    end

    always_comb begin
        running = 1'b0;
        start   = 1'b0;
        advance = 1'b0;
        unique case (state_q)
            ST_IDLE: start = en_req && cnt_nz;
            ST_RUN: begin
                running = 1'b1;
                advance = beat_done && !dis_req && !clash;
            end
        endcase
    end

    AST_START_ARMS: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> running); // R2

    AST_CLASH_HALTS: assert property (@(posedge clk) disable iff (!rst_n)
        clash |=> !running); // R10

    AST_LAST_HALTS: assert property (@(posedge clk) disable iff (!rst_n)
        (advance && last_item && !wrap) |=> !running); // R6

    AST_WRAP_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        (advance && last_item && wrap) |=> running); // R7

endmodule

// File: rtl/dseq_walker.sv
module dseq_walker
    import dseq_pkg::*;
#(
    parameter int unsigned ADDR_W = 32,
    parameter int unsigned CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              running,
    input  logic              start,
    input  logic              advance,
    input  logic              clash,
    input  ctl_t              ctl_q,
    input  ctl_t              ctl_d,
    input  logic [CNT_W-1:0]  cnt_q,
    input  logic [ADDR_W-1:0] pbase_q,
    input  logic [ADDR_W-1:0] m0_q,
    input  logic [ADDR_W-1:0] m1_q,
    input  logic [2:0]        clr_flags,
    output logic [ADDR_W-1:0] p_cur,
    output logic [ADDR_W-1:0] m_cur,
    output logic [CNT_W-1:0]  rem,
    output logic              tgt,
    output logic              last_item,
    output logic              wrap,
    output logic              f_half,
    output logic              f_done,
    output logic              f_err
);

    localparam logic [CNT_W-1:0]  ONE   = {{(CNT_W-1){1'b0}}, 1'b1};
    localparam int unsigned       PADW  = ADDR_W - 3;

    logic [CNT_W-1:0]  rem_nx;
    logic [ADDR_W-1:0] pstride, mstride;
    logic              tgt_flip;
    logic              half_hit, done_hit;

    always_comb begin
        wrap      = ctl_q.wrap || ctl_q.ping;
        last_item = (rem == ONE);
        rem_nx    = rem - ONE;
        tgt_flip  = tgt ^ ctl_q.ping;
        half_hit  = advance && (rem_nx == (cnt_q >> 1));
        done_hit  = advance && last_item;
        mstride   = ctl_q.mstep ? {{PADW{1'b0}}, size_bytes(ctl_q.msize)} : '0;
        if (!ctl_q.pstep)    pstride = '0;
        else if (ctl_q.pfix) pstride = {{PADW{1'b0}}, 3'd4};
        else                 pstride = {{PADW{1'b0}}, size_bytes(ctl_q.psize)};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            p_cur <= '0;
            m_cur <= '0;
            rem   <= '0;
            tgt   <= 1'b0;
        end else if (start) begin
            p_cur <= pbase_q;
            m_cur <= ctl_d.init_tgt ? m1_q : m0_q;
            rem   <= cnt_q;
            tgt   <= ctl_d.init_tgt;
        end else if (advance) begin
            if (last_item && wrap) begin
                p_cur <= pbase_q;
                m_cur <= tgt_flip ? m1_q : m0_q;
                rem   <= cnt_q;
                tgt   <= tgt_flip;
            end else begin
                p_cur <= p_cur + pstride;
                m_cur <= m_cur + mstride;
                rem   <= rem_nx;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            f_half <= 1'b0;
            f_done <= 1'b0;
            f_err  <= 1'b0;
        end else begin
            f_half <= half_hit || (f_half && !clr_flags[0]);
            f_done <= done_hit || (f_done && !clr_flags[1]);
            f_err  <= clash    || (f_err  && !clr_flags[2]);
        end
    end

    AST_IDLE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (!start && !advance) |=> ($stable(rem) && $stable(p_cur) && $stable(m_cur))); // R5

    AST_RUN_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
        running |-> (rem != '0)); // R7

    AST_TGT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!start && !(advance && last_item)) |=> $stable(tgt)); // R8

    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (f_err && !clr_flags[2]) |=> f_err); // R13

endmodule

// File: rtl/dma_seq_stream.sv
module dma_seq_stream
    import dseq_pkg::*;
#(
    parameter int unsigned ADDR_W = 32,
    parameter int unsigned CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [2:0]        wr_sel,
    input  logic [ADDR_W-1:0] wr_data,
    input  logic              beat_done,
    input  logic [2:0]        clr_flags,
    output logic              enabled,
    output logic              cur_target,
    output logic [ADDR_W-1:0] periph_addr,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [CNT_W-1:0]  items_left,
    output logic              flag_half,
    output logic              flag_done,
    output logic              flag_err
);

    ctl_t              ctl_q, ctl_d;
    logic [CNT_W-1:0]  cnt_q;
    logic [ADDR_W-1:0] pbase_q, m0_q, m1_q;
    logic              en_req, dis_req, clash;
    logic              running, start, advance;
    logic              last_item, wrap, tgt;

    dseq_regs #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_sel  (wr_sel),
        .wr_data (wr_data),
        .running (running),
        .cur_tgt (tgt),
        .ctl_q   (ctl_q),
        .ctl_d   (ctl_d),
        .cnt_q   (cnt_q),
        .pbase_q (pbase_q),
        .m0_q    (m0_q),
        .m1_q    (m1_q),
        .en_req  (en_req),
        .dis_req (dis_req),
        .clash   (clash)
    );

    dseq_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .en_req    (en_req),
        .dis_req   (dis_req),
        .clash     (clash),
        .beat_done (beat_done),
        .last_item (last_item),
        .wrap      (wrap),
        .cnt_nz    (cnt_q != '0),
        .running   (running),
        .start     (start),
        .advance   (advance)
    );

    dseq_walker #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_walk (
        .clk       (clk),
        .rst_n     (rst_n),
        .running   (running),
        .start     (start),
        .advance   (advance),
        .clash     (clash),
        .ctl_q     (ctl_q),
        .ctl_d     (ctl_d),
        .cnt_q     (cnt_q),
        .pbase_q   (pbase_q),
        .m0_q      (m0_q),
        .m1_q      (m1_q),
        .clr_flags (clr_flags),
        .p_cur     (periph_addr),
        .m_cur     (mem_addr),
        .rem       (items_left),
        .tgt       (tgt),
        .last_item (last_item),
        .wrap      (wrap),
        .f_half    (flag_half),
        .f_done    (flag_done),
        .f_err     (flag_err)
    );

    assign enabled    = running;
    assign cur_target = tgt;

endmodule

// File: tb/sim_dma_seq_stream.sv
module sim_dma_seq_stream;

    localparam int CLK_PERIOD = 10;
    localparam int AW = 32;
    localparam int CW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic [2:0]    wr_sel = '0;
    logic [AW-1:0] wr_data = '0;
    logic          beat_done = 1'b0;
    logic [2:0]    clr_flags = '0;
    logic          enabled, cur_target, flag_half, flag_done, flag_err;
    logic [AW-1:0] periph_addr, mem_addr;
    logic [CW-1:0] items_left;

    int checks = 0;
    int errors = 0;

    dma_seq_stream #(.ADDR_W(AW), .CNT_W(CW)) u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .beat_done(beat_done), .clr_flags(clr_flags),
        .enabled(enabled), .cur_target(cur_target), .periph_addr(periph_addr),
        .mem_addr(mem_addr), .items_left(items_left), .flag_half(flag_half),
        .flag_done(flag_done), .flag_err(flag_err)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [31:0] ctl(input logic en, input logic [1:0] dir,
        input logic wrp, input logic png, input logic ms_en, input logic ps_en,
        input logic pfx, input logic [1:0] ms, input logic [1:0] ps, input logic tg);
        return {19'd0, tg, ps, ms, pfx, ps_en, ms_en, png, wrp, dir, en};
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] s, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = s; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic beat();
        @(negedge clk);
        beat_done = 1'b1;
        @(negedge clk);
        beat_done = 1'b0;
    endtask

    task automatic clr(input logic [2:0] m);
        @(negedge clk);
        clr_flags = m;
        @(negedge clk);
        clr_flags = '0;
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin : main
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk("R1 enabled", {31'd0, enabled}, 32'd0);
        chk("R1 periph", periph_addr, 32'd0);
        chk("R1 mem", mem_addr, 32'd0);
        chk("R1 items", {16'd0, items_left}, 32'd0);
        chk("R1 flags", {29'd0, flag_half, flag_done, flag_err}, 32'd0);
        chk("R1 target", {31'd0, cur_target}, 32'd0);

        // R2 enabling with count 0 has no effect
        wr(3'd1, 32'd0);
        wr(3'd0, ctl(1, 0, 0, 0, 1, 1, 0, 0, 0, 0));
        chk("R2 zero count", {31'd0, enabled}, 32'd0);

        // R3 R4 R5 R6 sweep of sizes and step modes
        for (int ms = 0; ms < 3; ms++)
        for (int ps = 0; ps < 3; ps++)
        for (int mi = 0; mi < 2; mi++)
        for (int pi = 0; pi < 2; pi++)
        for (int pf = 0; pf < 2; pf++) begin
            int mst, pst;
            mst = mi ? (1 << ms) : 0;
            pst = pi ? (pf ? 4 : (1 << ps)) : 0;
            wr(3'd2, 32'h100);
            wr(3'd3, 32'h8000);
            wr(3'd1, 32'd5);
            wr(3'd0, ctl(1, 0, 0, 0, mi[0], pi[0], pf[0], ms[1:0], ps[1:0], 0));
            chk("R2 load periph", periph_addr, 32'h100);
            chk("R2 load mem", mem_addr, 32'h8000);
            for (int k = 1; k <= 5; k++) begin
                beat();
                chk("R3 mem step", mem_addr, 32'h8000 + k * mst);
                chk("R4 periph step", periph_addr, 32'h100 + k * pst);
                chk("R5 count", {16'd0, items_left}, 32'(5 - k));
            end
            chk("R6 disabled", {31'd0, enabled}, 32'd0);
            chk("R6 done", {31'd0, flag_done}, 32'd1);
            beat();
            chk("R5 idle beat", {16'd0, items_left}, 32'd0);
            chk("R5 idle beat mem", mem_addr, 32'h8000 + 5 * mst);
            clr(3'b111);
        end

        // R7 wrap mode
        wr(3'd2, 32'h40);
        wr(3'd3, 32'h500);
        wr(3'd1, 32'd3);
        wr(3'd0, ctl(1, 0, 1, 0, 1, 1, 0, 2, 1, 0));
        repeat (3) beat();
        chk("R7 items reload", {16'd0, items_left}, 32'd3);
        chk("R7 periph reload", periph_addr, 32'h40);
        chk("R7 mem reload", mem_addr, 32'h500);
        chk("R7 still enabled", {31'd0, enabled}, 32'd1);
        chk("R7 done", {31'd0, flag_done}, 32'd1);
        beat();
        chk("R7 after wrap mem", mem_addr, 32'h504);
        chk("R7 after wrap periph", periph_addr, 32'h42);

        // R13 selective clear
        clr(3'b010);
        chk("R13 done cleared", {31'd0, flag_done}, 32'd0);
        chk("R13 half kept", {31'd0, flag_half}, 32'd1);
        wr(3'd0, ctl(0, 0, 1, 0, 1, 1, 0, 2, 1, 0));
        chk("R12 disable", {31'd0, enabled}, 32'd0);
        clr(3'b111);

        // R8 R9 R10 ping-pong
        wr(3'd2, 32'h10);
        wr(3'd3, 32'h1000);
        wr(3'd4, 32'h2000);
        wr(3'd1, 32'd5);
        wr(3'd0, ctl(1, 0, 0, 1, 1, 0, 0, 0, 0, 0));
        chk("R2 mem from ptr0", mem_addr, 32'h1000);
        chk("R2 target", {31'd0, cur_target}, 32'd0);
        repeat (2) beat();
        chk("R9 half not yet", {31'd0, flag_half}, 32'd0);
        beat();
        chk("R9 half set", {31'd0, flag_half}, 32'd1);
        wr(3'd4, 32'h3000);
        chk("R10 idle ptr write keeps run", {31'd0, enabled}, 32'd1);
        repeat (2) beat();
        chk("R8 target toggled", {31'd0, cur_target}, 32'd1);
        chk("R10 new ptr used", mem_addr, 32'h3000);
        chk("R8 count reload", {16'd0, items_left}, 32'd5);
        chk("R8 still enabled", {31'd0, enabled}, 32'd1);
        wr(3'd4, 32'h7777);
        chk("R10 clash disables", {31'd0, enabled}, 32'd0);
        chk("R10 clash error", {31'd0, flag_err}, 32'd1);
        wr(3'd0, ctl(1, 0, 0, 1, 1, 0, 0, 0, 0, 1));
        chk("R10 discarded write", mem_addr, 32'h3000);
        chk("R2 initial target 1", {31'd0, cur_target}, 32'd1);
        wr(3'd0, ctl(0, 0, 0, 1, 1, 0, 0, 0, 0, 1));
        clr(3'b111);

        // R11 mem-to-mem strips wrap and ping-pong
        wr(3'd3, 32'h200);
        wr(3'd1, 32'd2);
        wr(3'd0, ctl(1, 2, 1, 1, 1, 0, 0, 0, 0, 0));
        repeat (2) beat();
        chk("R11 stops", {31'd0, enabled}, 32'd0);
        chk("R11 items", {16'd0, items_left}, 32'd0);
        chk("R11 mem", mem_addr, 32'h202);
        clr(3'b111);

        // R12 writes ignored while enabled
        wr(3'd2, 32'h900);
        wr(3'd3, 32'h100);
        wr(3'd1, 32'd4);
        wr(3'd0, ctl(1, 0, 0, 0, 1, 1, 0, 0, 0, 0));
        wr(3'd1, 32'd9);
        wr(3'd2, 32'hA00);
        wr(3'd0, ctl(1, 0, 0, 0, 1, 1, 0, 2, 2, 0));
        beat();
        chk("R12 mem old step", mem_addr, 32'h101);
        chk("R12 periph old step", periph_addr, 32'h901);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = 3'd0; wr_data = ctl(0, 0, 0, 0, 1, 1, 0, 0, 0, 0);
        beat_done = 1'b1;
        @(negedge clk);
        wr_en = 1'b0; beat_done = 1'b0;
        chk("R12 disable now", {31'd0, enabled}, 32'd0);
        chk("R12 beat dropped", {16'd0, items_left}, 32'd3);
        wr(3'd0, ctl(1, 0, 0, 0, 1, 1, 0, 0, 0, 0));
        chk("R12 count kept", {16'd0, items_left}, 32'd4);
        chk("R12 paddr kept", periph_addr, 32'h900);
        wr(3'd3, 32'h555);
        wr(3'd0, ctl(0, 0, 0, 0, 1, 1, 0, 0, 0, 0));
        wr(3'd0, ctl(1, 0, 0, 0, 1, 1, 0, 0, 0, 0));
        chk("R12 ptr kept", mem_addr, 32'h100);
        wr(3'd0, ctl(0, 0, 0, 0, 1, 1, 0, 0, 0, 0));
        clr(3'b111);

        // R13 set wins over clear; R9 count of 1
        wr(3'd1, 32'd1);
        wr(3'd0, ctl(1, 0, 0, 0, 0, 0, 0, 0, 0, 0));
        @(negedge clk);
        beat_done = 1'b1; clr_flags = 3'b011;
        @(negedge clk);
        beat_done = 1'b0; clr_flags = 3'b000;
        chk("R13 done survives clear", {31'd0, flag_done}, 32'd1);
        chk("R9 half with count 1", {31'd0, flag_half}, 32'd1);
        chk("R6 single item stop", {31'd0, enabled}, 32'd0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule